// File: doc/BRIEF.md
# I2C Byte Bit Counter

This block paces one byte of an I2C-style serial transfer at bit level. A controller sets a small count field to choose how many data bits the next byte carries. It may also request an extra acknowledge clock. The block then counts strobes that mark SCL rising edges. Once the byte's last clock has been seen, it raises a single-cycle interrupt and reloads the count field to zero, so the next byte defaults to a full frame.

When a START condition is detected, the block does three things: it clears its bit position, it clears the count field, and it arms a forced full-width frame. The address byte that follows START is therefore always a full 8 bits, whatever the field holds. Clearing the enable input, or pulsing the soft reset, returns the sequencer to idle, and strobes arriving in that state are ignored. Every input is a plain level or a strobe that is sampled on the system clock. There is no stream data path, so no valid/ready handshake applies.

Top module: `i2c_byte_bitcount`

## Requirements
- R1: The byte length is taken from the 3-bit count field. Field value 0 means 8 data bits, and values 1 to 7 mean that many data bits.
- R2: `irq` is high for exactly one clock cycle. It rises in the cycle after the SCL strobe that completes the byte is sampled, and `bit_idx` reads 0 in that cycle.
- R3: If `ack_en` is high when a byte's first SCL strobe is sampled, that byte takes one extra clock before `irq`. `ack_phase` is high only after the last data clock and before that acknowledge clock. Changing `ack_en` in the middle of a byte has no effect on that byte.
- R4: Once a byte completes, `count_field` reads 0 unless R8 applies.
- R5: A START strobe while enabled clears `bit_idx` and `count_field` to 0 on the next cycle. It overrides an SCL strobe or a field write sampled in the same cycle.
- R6: The first byte after START is always 8 data bits, even if the field is written between START and that byte's first clock.
- R7: While `enable` is low or `soft_rst` is high, `bit_idx` goes to 0, any pending forced address frame is dropped, no `irq` is raised, and SCL and START strobes are ignored.
- R8: A field write made while a byte is in progress does not change that byte's length. The written value survives the byte's completion and sets the following byte's length.
- R9: `bit_idx` reports how many SCL clocks of the current byte have been taken, from 0 up to the byte's total, where the total returns to 0.
- R10: After `rst_n` is released, `bit_idx`, `count_field`, `ack_phase` and `irq` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable; low holds the sequencer idle |
| soft_rst | input | 1 | Synchronous reset of the sequencer while high |
| start_det | input | 1 | One-cycle strobe: START condition seen on the bus |
| scl_rise | input | 1 | One-cycle strobe: SCL rising edge seen |
| cnt_wr | input | 1 | Write strobe for the count field |
| cnt_wdata | input | 3 | Value written to the count field |
| ack_en | input | 1 | Add an acknowledge clock to the byte |
| count_field | output | 3 | Current count field value |
| bit_idx | output | 4 | Clocks taken so far in the current byte |
| ack_phase | output | 1 | High while waiting for the acknowledge clock |
| irq | output | 1 | One-cycle byte-complete interrupt pulse |

## Verification
The embedded assertions are evaluated on every cycle. They cover three things: the single-cycle shape of the interrupt and its alignment with a zero bit index, the clearing effect of START and of disable, and the bound that keeps the bit index within the latched byte length. The bench's scenarios are the only way to show the rest. That includes the exact edge count for every field value with and without an acknowledge clock, the forced 8-bit frame after START, and a mid-byte write that carries over to the next byte. It also includes the dropped address force after a soft reset.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;

  // Data bits for a byte: a zero field means a full frame, as does a forced frame.
  function automatic int unsigned bc_data_bits(input int unsigned field,
                                               input int unsigned full,
                                               input bit force_full);
    if (force_full || field == 0) return full;
    return field;
  endfunction

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DATA = 2'd1,
    SEQ_ACK  = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/bc_field_reg.sv
module bc_field_reg #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             clr_start,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             byte_busy,
  input  logic             byte_done,
  output logic [CNT_W-1:0] field_q
);

  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      held_q  <= 1'b0;
    end else if (clr_start) begin
      field_q <= '0;
      held_q  <= 1'b0;
    end else begin
      if (wr_en)                     field_q <= wr_data;
      else if (byte_done && !held_q) field_q <= '0;

      if (!go || byte_done)          held_q <= 1'b0;
      else if (wr_en && byte_busy)   held_q <= 1'b1;
    end
  end

  AST_FIELD_CLR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start |=> field_q == '0); // R5

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_start) |=> field_q == $past(wr_data)); // R8

endmodule

// File: rtl/bc_sequencer.sv
module bc_sequencer
  import i2c_bc_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             start_det,
  input  logic             scl_rise,
  input  logic             ack_en,
  input  logic [CNT_W-1:0] field_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             byte_busy,
  output logic             byte_done,
  output logic             ack_phase,
  output logic             irq_q
);

  localparam int FULL = 1 << CNT_W;

  logic [IDX_W-1:0] len_q, eff_len, idx_nx, total;
  logic             ack_q, eff_ack, addr_pend_q;
  logic             st, rise, first;
  seq_phase_e       phase;

  assign st    = go && start_det;
  assign rise  = go && scl_rise && !start_det;
  assign first = rise && (idx_q == '0);

  always_comb begin
    eff_len = len_q;
    eff_ack = ack_q;
    if (first) begin
      eff_len = IDX_W'(bc_data_bits(int'(field_q), FULL, addr_pend_q));
      eff_ack = ack_en;
    end
    total     = eff_len + IDX_W'(eff_ack);
    idx_nx    = idx_q + 1'b1;
    byte_done = rise && (idx_nx == total);
    byte_busy = (idx_q != '0) || rise;
  end

  always_comb begin
    if (idx_q == '0)                        phase = SEQ_IDLE;
    else if (ack_q && idx_q == len_q)       phase = SEQ_ACK;
    else                                    phase = SEQ_DATA;
  end
  assign ack_phase = (phase == SEQ_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q       <= '0;
      len_q       <= IDX_W'(FULL);
      ack_q       <= 1'b0;
      addr_pend_q <= 1'b0;
      irq_q       <= 1'b0;
    end else if (!go) begin
      idx_q       <= '0;
      addr_pend_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= byte_done;
      if (st) begin
        idx_q       <= '0;
        addr_pend_q <= 1'b1;
      end else if (rise) begin
        idx_q <= byte_done ? '0 : idx_nx;
        if (first) begin
          len_q       <= eff_len;
          ack_q       <= eff_ack;
          addr_pend_q <= 1'b0;
        end
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len_q); // R9

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> (idx_q == '0 || idx_q == $past(idx_q) + 1'b1)); // R9

  AST_ACK_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_phase |-> idx_q != '0); // R3

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= 1) && (len_q <= IDX_W'(FULL))); // R1

endmodule

// File: rtl/i2c_byte_bitcount.sv
module i2c_byte_bitcount #(
  parameter int CNT_W = 3,
  localparam int FULL  = 1 << CNT_W,
  localparam int IDX_W = $clog2(FULL + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             soft_rst,
  input  logic             start_det,
  input  logic             scl_rise,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ack_en,
  output logic [CNT_W-1:0] count_field,
  output logic [IDX_W-1:0] bit_idx,
  output logic             ack_phase,
  output logic             irq
);

  logic go, busy, done;

  assign go = enable && !soft_rst;

  bc_field_reg #(.CNT_W(CNT_W)) u_field (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .clr_start (go && start_det),
    .wr_en     (cnt_wr),
    .wr_data   (cnt_wdata),
    .byte_busy (busy),
    .byte_done (done),
    .field_q   (count_field)
  );

  bc_sequencer #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .start_det (start_det),
    .scl_rise  (scl_rise),
    .ack_en    (ack_en),
    .field_q   (count_field),
    .idx_q     (bit_idx),
    .byte_busy (busy),
    .byte_done (done),
    .ack_phase (ack_phase),
    .irq_q     (irq)
  );

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R2

  AST_IRQ_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> bit_idx == '0); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && start_det) |=> (bit_idx == '0 && !irq)); // R5

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (bit_idx == '0 && !irq)); // R7

endmodule

// File: tb/sim_i2c_byte_bitcount.sv
`timescale 1ns/100ps
module sim_i2c_byte_bitcount;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, soft_rst = 1'b0, start_det = 1'b0, scl_rise = 1'b0;
  logic       cnt_wr = 1'b0, ack_en = 1'b0;
  logic [2:0] cnt_wdata = 3'd0;
  logic [2:0] count_field;
  logic [3:0] bit_idx;
  logic       ack_phase, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_byte_bitcount u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .start_det(start_det), .scl_rise(scl_rise), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .ack_en(ack_en), .count_field(count_field),
    .bit_idx(bit_idx), .ack_phase(ack_phase), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe_scl();
    @(negedge clk); scl_rise = 1'b1;
    @(negedge clk); scl_rise = 1'b0;
  endtask

  task automatic strobe_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic write_field(input int v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 3'(v);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  // Run a whole byte of nbits data clocks plus optional ack clock, checking each step.
  task automatic run_byte(input int nbits, input int ack, input string req);
    int total = nbits + ack;
    for (int k = 1; k <= total; k++) begin
      strobe_scl();
      chk({req, " R9 bit_idx"}, int'(bit_idx), (k == total) ? 0 : k);
      chk({req, " R2 irq"}, int'(irq), (k == total) ? 1 : 0);
      chk({req, " R3 ack_phase"}, int'(ack_phase), (ack == 1 && k == nbits) ? 1 : 0);
    end
    @(negedge clk);
    chk({req, " R2 irq single cycle"}, int'(irq), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 bit_idx", int'(bit_idx), 0);
    chk("R10 count_field", int'(count_field), 0);
    chk("R10 ack_phase", int'(ack_phase), 0);
    chk("R10 irq", int'(irq), 0);

    enable = 1'b1;
    @(negedge clk);

    // R1 R3 R4: every field value with and without ack clock
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 2; a++) begin
        ack_en = a[0];
        write_field(f);
        run_byte((f == 0) ? 8 : f, a, "R1");
        chk("R4 field cleared", int'(count_field), 0);
      end
    end

    // R5 R6: START then a write; byte is still a full frame
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 2; a++) begin
        ack_en = a[0];
        write_field(5);
        strobe_start();
        chk("R5 field after start", int'(count_field), 0);
        chk("R5 idx after start", int'(bit_idx), 0);
        write_field(f);
        run_byte(8, a, "R6");
        chk("R6 field after addr byte", int'(count_field), 0);
      end
    end

    // R3: ack_en change mid-byte is ignored
    ack_en = 1'b0;
    write_field(2);
    strobe_scl();
    ack_en = 1'b1;
    strobe_scl();
    chk("R3 no ack latched: irq", int'(irq), 1);
    chk("R3 no ack latched: ack_phase", int'(ack_phase), 0);
    ack_en = 1'b0;
    @(negedge clk);

    // R8: mid-byte write keeps current length and survives completion
    write_field(3);
    strobe_scl();
    write_field(5);
    strobe_scl();
    chk("R8 second clock no irq", int'(irq), 0);
    strobe_scl();
    chk("R8 byte ends at old length", int'(irq), 1);
    chk("R8 written value kept", int'(count_field), 5);
    @(negedge clk);
    run_byte(5, 0, "R8 next byte");

    // R5: START mid-byte clears progress; simultaneous scl strobe loses
    write_field(4);
    strobe_scl();
    strobe_scl();
    chk("R5 pre idx", int'(bit_idx), 2);
    @(negedge clk); start_det = 1'b1; scl_rise = 1'b1;
    @(negedge clk); start_det = 1'b0; scl_rise = 1'b0;
    chk("R5 start beats scl idx", int'(bit_idx), 0);
    chk("R5 start clears field", int'(count_field), 0);
    // R5: start beats a same-cycle write
    @(negedge clk); start_det = 1'b1; cnt_wr = 1'b1; cnt_wdata = 3'd6;
    @(negedge clk); start_det = 1'b0; cnt_wr = 1'b0;
    chk("R5 start beats write", int'(count_field), 0);
    run_byte(8, 0, "R5 addr byte");

    // R7: disable mid-byte
    write_field(6);
    strobe_scl(); strobe_scl(); strobe_scl();
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    chk("R7 disable idx", int'(bit_idx), 0);
    strobe_scl(); strobe_scl();
    chk("R7 scl ignored idx", int'(bit_idx), 0);
    chk("R7 scl ignored irq", int'(irq), 0);
    strobe_start();
    chk("R7 start ignored field", int'(count_field), 6);
    @(negedge clk); enable = 1'b1;
    run_byte(6, 0, "R7 after enable");

    // R7: soft reset drops pending address force
    strobe_start();
    write_field(2);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R7 soft reset idx", int'(bit_idx), 0);
    run_byte(2, 0, "R7 force dropped");

    // R7: soft reset mid-byte
    write_field(7);
    strobe_scl(); strobe_scl();
    @(negedge clk); soft_rst = 1'b1;
    strobe_scl();
    chk("R7 soft reset held idx", int'(bit_idx), 0);
    @(negedge clk); soft_rst = 1'b0;
    run_byte(7, 0, "R7 after soft reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule